// File: doc/BRIEF.md
# Three-Semaphore Ping-Pong Privilege Sequencer

This block sits beside one of two processors that share a buffer. It hands an exclusive right to use that buffer back and forth between the two sides. The only shared mechanism is a bank of three hardware semaphores, numbered 0, 1 and 2. A side holds the privilege exactly when it holds two of the three semaphores. It gives the privilege up by releasing the semaphore it has held longest. The other side then completes its pair by acquiring that semaphore. There is no shared state word, and the hand-off does not depend on timing.

Each instance talks to the semaphore bank through a request channel (valid/ready, with an opcode and a semaphore index) and a response channel (valid, with a grant flag). It raises `own` while the privilege is local. While it owns, a high `pass_req` hands the privilege to the other side. The `ROLE` parameter sets the start position. After reset, both sides claim their starting semaphores. They then wait `WAIT_CYC` cycles so that the peer has finished its own claims, and only then does the rotation begin.

Top module: `pp_sequencer`

## Requirements
- R1: After reset, `own` is low and the block requests an acquire (`req_op`=0) of its starting semaphores. Role 0 acquires index 0 and then index 1. Role 1 acquires index 2.
- R2: After the grant that completes the starting claims, the block issues no request and keeps `own` low for `WAIT_CYC`+1 cycles. For role 0, `own` then rises on the (`WAIT_CYC`+1)-th clock edge after that grant edge. Role 1 issues its first run-time acquire after the same edge.
- R3: Encodings. `req_op` 0 means acquire and 1 means release. `req_sem` takes only the values 0, 1 and 2, never 3. `rsp_grant` 1 means granted and 0 means denied, and it is meaningful only with `rsp_valid`.
- R4: A request stays asserted with a stable opcode and index until `req_ready` is high. At most one request is outstanding at a time, and `req_valid` stays low until its response arrives.
- R5: During the rotation, `own` rises one cycle after the grant of the acquire that gives the block its second semaphore.
- R6: When `own` and `pass_req` are both high at a clock edge, `own` falls at that edge. In the same cycle a release request appears for the semaphore held longest.
- R7: The acquire target is the semaphore that is neither held nor just released. Let k count the hand-offs from 0 upward. For role 0, release number k targets index k mod 3 and acquire number k targets (k+2) mod 3. For role 1, acquire number k targets index k mod 3 and release number k targets (k+2) mod 3.
- R8: During the rotation, completed operations alternate strictly between acquire and release. Neither two acquires nor two releases follow each other.
- R9: After a denied acquire, `own` stays low and the same acquire is requested again until it is granted.
- R10: `pass_req` has no effect while the block does not own the privilege.
- R11: While `own` is high, the block issues no request.
- R12: A role 0 and a role 1 instance on one bank never own at the same time. Each owns three times per six hand-offs, and the rotation keeps going indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_req | input | 1 | Hand the privilege to the peer (acted on only while owning) |
| own | output | 1 | Privilege held locally; shared buffer may be used |
| req_valid | output | 1 | Semaphore request valid |
| req_ready | input | 1 | Semaphore bank accepts the request |
| req_op | output | 1 | 0 acquire, 1 release |
| req_sem | output | 2 | Semaphore index 0..2 |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_grant | input | 1 | 1 granted, 0 denied |

## Verification
The internal state is a rotation position plus a phase. A wrong position shows up at the next accepted request as a wrong semaphore index, so it is visible within one hand-off. The bank model also turns it into a deny loop, which stops progress. A wrong phase shows up either as `own` disagreeing with the semaphores the bank says the block holds, or as two acquires or two releases in a row. That is visible one cycle after the grant, or in the same cycle as the request. A wrong start-up count moves the first rising edge of `own` or the first request of role 1 by whole cycles, and each cycle is compared.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;

    typedef logic [1:0] sem_idx_t;

    localparam sem_idx_t SEM_0 = 2'd0;
    localparam sem_idx_t SEM_1 = 2'd1;
    localparam sem_idx_t SEM_2 = 2'd2;

    localparam logic OP_ACQ = 1'b0;
    localparam logic OP_REL = 1'b1;

    typedef enum logic [2:0] {
        ST_INIT_REQ,
        ST_INIT_RSP,
        ST_WAIT,
        ST_OWN,
        ST_REL_REQ,
        ST_REL_RSP,
        ST_ACQ_REQ,
        ST_ACQ_RSP
    } seq_state_e;

    // index that is neither x nor y (x != y, both in 0..2)
    function automatic sem_idx_t third_sem(sem_idx_t x, sem_idx_t y);
        return 2'd3 - x - y;
    endfunction

endpackage

// File: rtl/pp_timer.sv
`timescale 1ns/1ps
module pp_timer #(
    parameter int WAIT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(WAIT_CYC);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{busy: 1'b0, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pp_rotor.sv
`timescale 1ns/1ps
module pp_rotor
    import pp_pkg::*;
#(
    parameter int ROLE = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     advance,
    output sem_idx_t old_sem,
    output sem_idx_t new_sem,
    output sem_idx_t next_sem
);
    // old_sem: longest held (or just released); new_sem: most recent
    localparam sem_idx_t OLD_RST = (ROLE == 0) ? SEM_0 : SEM_1;
    localparam sem_idx_t NEW_RST = (ROLE == 0) ? SEM_1 : SEM_2;

    typedef struct packed {
        sem_idx_t older;
        sem_idx_t newer;
    } rot_s;

    rot_s rot_d, rot_q;

    assign old_sem  = rot_q.older;
    assign new_sem  = rot_q.newer;
    assign next_sem = third_sem(rot_q.older, rot_q.newer);

    always_comb begin
        rot_d = rot_q;
        if (advance) begin
            rot_d.older = rot_q.newer;
            rot_d.newer = third_sem(rot_q.older, rot_q.newer);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_q <= '{older: OLD_RST, newer: NEW_RST};
        end else begin
            rot_q <= rot_d;
        end
    end

endmodule

// File: rtl/pp_ctrl.sv
`timescale 1ns/1ps
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int ROLE = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pass_req,
    input  logic     req_ready,
    input  logic     rsp_valid,
    input  logic     rsp_grant,
    input  logic     timer_done,
    input  sem_idx_t old_sem,
    input  sem_idx_t new_sem,
    input  sem_idx_t next_sem,
    output logic     req_valid,
    output logic     req_op,
    output sem_idx_t req_sem,
    output logic     own,
    output logic     timer_start,
    output logic     rotor_adv,
    output logic     init_done
);
    typedef struct packed {
        seq_state_e st;
        logic       init_cnt;
        logic       own;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic last_init;

    // role 0 claims two semaphores at start-up, role 1 one
    assign last_init = (ROLE == 0) ? ctl_q.init_cnt : 1'b1;
    assign own       = ctl_q.own;
    assign init_done = !(ctl_q.st inside {ST_INIT_REQ, ST_INIT_RSP, ST_WAIT});

    always_comb begin
        ctl_d       = ctl_q;
        req_valid   = 1'b0;
        req_op      = OP_ACQ;
        req_sem     = new_sem;
        timer_start = 1'b0;
        rotor_adv   = 1'b0;
        unique case (ctl_q.st)
            ST_INIT_REQ: begin
                req_valid = 1'b1;
                req_sem   = (ROLE == 0 && !ctl_q.init_cnt) ? old_sem : new_sem;
                if (req_ready) ctl_d.st = ST_INIT_RSP;
            end
            ST_INIT_RSP: begin
                if (rsp_valid) begin
                    if (!rsp_grant) begin
                        ctl_d.st = ST_INIT_REQ;
                    end else if (last_init) begin
                        ctl_d.st    = ST_WAIT;
                        timer_start = 1'b1;
                    end else begin
                        ctl_d.init_cnt = 1'b1;
                        ctl_d.st       = ST_INIT_REQ;
                    end
                end
            end
            ST_WAIT: begin
                if (timer_done) begin
                    if (ROLE == 0) begin
                        ctl_d.st  = ST_OWN;
                        ctl_d.own = 1'b1;
                    end else begin
                        ctl_d.st = ST_ACQ_REQ;
                    end
                end
            end
            ST_OWN: begin
                if (pass_req) begin
                    ctl_d.st  = ST_REL_REQ;
                    ctl_d.own = 1'b0;
                end
            end
            ST_REL_REQ: begin
                req_valid = 1'b1;
                req_op    = OP_REL;
                req_sem   = old_sem;
                if (req_ready) ctl_d.st = ST_REL_RSP;
            end
            ST_REL_RSP: begin
                if (rsp_valid) ctl_d.st = ST_ACQ_REQ;
            end
            ST_ACQ_REQ: begin
                req_valid = 1'b1;
                req_sem   = next_sem;
                if (req_ready) ctl_d.st = ST_ACQ_RSP;
            end
            ST_ACQ_RSP: begin
                if (rsp_valid) begin
                    if (rsp_grant) begin
                        ctl_d.st  = ST_OWN;
                        ctl_d.own = 1'b1;
                        rotor_adv = 1'b1;
                    end else begin
                        ctl_d.st = ST_ACQ_REQ;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_INIT_REQ, init_cnt: 1'b0, own: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/pp_sequencer.sv
`timescale 1ns/1ps
module pp_sequencer
    import pp_pkg::*;
#(
    parameter int ROLE     = 0,
    parameter int WAIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pass_req,
    output logic       own,
    output logic       req_valid,
    input  logic       req_ready,
    output logic       req_op,
    output logic [1:0] req_sem,
    input  logic       rsp_valid,
    input  logic       rsp_grant
);
    sem_idx_t old_sem, new_sem, next_sem;
    logic     timer_start, timer_done, rotor_adv, init_done;

    pp_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .done  (timer_done)
    );

    pp_rotor #(.ROLE(ROLE)) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (rotor_adv),
        .old_sem  (old_sem),
        .new_sem  (new_sem),
        .next_sem (next_sem)
    );

    pp_ctrl #(.ROLE(ROLE)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pass_req    (pass_req),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_grant   (rsp_grant),
        .timer_done  (timer_done),
        .old_sem     (old_sem),
        .new_sem     (new_sem),
        .next_sem    (next_sem),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_sem     (req_sem),
        .own         (own),
        .timer_start (timer_start),
        .rotor_adv   (rotor_adv),
        .init_done   (init_done)
    );

endmodule

// File: rtl/pp_checker.sv
`timescale 1ns/1ps
module pp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pass_req,
    input logic       own,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_op,
    input logic [1:0] req_sem,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       init_done
);
    logic       out_q, out_op_q, have_done_q, last_op_q, have_rel_q;
    logic [1:0] out_sem_q, last_rel_q;
    logic       done_evt;

    assign done_evt = out_q && rsp_valid && (out_op_q || rsp_grant) && init_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q       <= 1'b0;
            out_op_q    <= 1'b0;
            out_sem_q   <= 2'd0;
            have_done_q <= 1'b0;
            last_op_q   <= 1'b0;
            have_rel_q  <= 1'b0;
            last_rel_q  <= 2'd0;
        end else begin
            if (req_valid && req_ready) begin
                out_q     <= 1'b1;
                out_op_q  <= req_op;
                out_sem_q <= req_sem;
            end else if (rsp_valid) begin
                out_q <= 1'b0;
            end
            if (done_evt) begin
                have_done_q <= 1'b1;
                last_op_q   <= out_op_q;
                if (out_op_q) begin
                    have_rel_q <= 1'b1;
                    last_rel_q <= out_sem_q;
                end
            end
        end
    end

    // R3
    a_r3_sem_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_sem != 2'd3);

    // R4
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_sem));

    // R4
    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !req_valid);

    // R5
    a_r5_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && out_q && !out_op_q && rsp_valid && rsp_grant |=> own);

    // R6
    a_r6_fall_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own) |-> req_valid && req_op);

    // R6
    a_r6_pass_taken: assert property (@(posedge clk) disable iff (!rst_n)
        own && pass_req |=> !own);

    // R7
    a_r7_no_reacquire: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && req_valid && !req_op && have_rel_q |-> req_sem != last_rel_q);

    // R8
    a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && req_valid && have_done_q |-> req_op != last_op_q);

    // R9
    a_r9_deny_no_own: assert property (@(posedge clk) disable iff (!rst_n)
        out_q && !out_op_q && rsp_valid && !rsp_grant |=> !own);

    // R11
    a_r11_owner_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> !req_valid);

endmodule

bind pp_sequencer pp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_req  (pass_req),
    .own       (own),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_sem   (req_sem),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .init_done (init_done)
);

// File: tb/sim_pp_sequencer.sv
`timescale 1ns/1ps
module sim_pp_sequencer;
    localparam int W    = 6;
    localparam int NCYC = 6000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pass_req = '0, own, req_valid, req_ready = '0, req_op;
    logic [1:0] rsp_valid = '0, rsp_grant = '0;
    logic [1:0] req_sem [2];

    pp_sequencer #(.ROLE(0), .WAIT_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .pass_req(pass_req[0]), .own(own[0]),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_op(req_op[0]),
        .req_sem(req_sem[0]), .rsp_valid(rsp_valid[0]), .rsp_grant(rsp_grant[0]));

    pp_sequencer #(.ROLE(1), .WAIT_CYC(W)) u1 (
        .clk(clk), .rst_n(rst_n), .pass_req(pass_req[1]), .own(own[1]),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_op(req_op[1]),
        .req_sem(req_sem[1]), .rsp_valid(rsp_valid[1]), .rsp_grant(rsp_grant[1]));

    always #2.5 clk = ~clk;

    int    ntests = 0, nfail = 0, denies = 0;
    bit    finished = 0;
    int    owner [3];
    int    n_done [2], wait_cnt [2], hold [2], owns [2];
    int    pend_sem [2], st_sem [2];
    bit    own_exp [2], pend [2], pend_op [2], fell_exp [2], ign [2], retry [2];
    bit    stall [2], st_op [2], have_run [2], last_run_op [2];
    string own_tag [2];

    function automatic int init_len(int p);
        return (p == 0) ? 2 : 1;
    endfunction

    function automatic int exp_op(int p, int n);
        int m;
        if (n < init_len(p)) return 0;
        m = n - init_len(p);
        if (p == 0) return (m % 2 == 0) ? 1 : 0;
        return (m % 2 == 0) ? 0 : 1;
    endfunction

    function automatic int exp_sem(int p, int n);
        int m;
        if (n < init_len(p)) return (p == 0) ? n : 2;
        m = n - init_len(p);
        return (m % 2 == 0) ? (m / 2) % 3 : (m / 2 + 2) % 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input int cyc);
        bit own_next [2];
        bit rv [2], rg [2], rdy, ps;
        int eo, es;
        string tag;
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk(own[p] === own_exp[p], own_tag[p], "own", int'(own[p]), int'(own_exp[p]));
            if (ign[p]) begin
                chk(own[p] === own_exp[p], "R10", "own after idle pass", int'(own[p]), int'(own_exp[p]));
                ign[p] = 0;
            end
            if (fell_exp[p]) begin
                chk(req_valid[p] === 1'b1 && req_op[p] === 1'b1, "R6", "release with fall",
                    int'(req_op[p]), 1);
                fell_exp[p] = 0;
            end
            if (wait_cnt[p] > 0)
                chk(req_valid[p] === 1'b0, "R2", "request during wait", int'(req_valid[p]), 0);
            if (own_exp[p])
                chk(req_valid[p] === 1'b0, "R11", "request while owning", int'(req_valid[p]), 0);
            if (req_valid[p])
                chk(req_sem[p] !== 2'd3, "R3", "sem index", int'(req_sem[p]), 0);
            if (stall[p])
                chk(req_valid[p] === 1'b1 && req_op[p] == st_op[p] && int'(req_sem[p]) == st_sem[p],
                    "R4", "held request", int'(req_sem[p]), st_sem[p]);
        end
        chk(!(own[0] === 1'b1 && own[1] === 1'b1), "R12", "both own", int'(own[0] & own[1]), 0);

        for (int p = 0; p < 2; p++) begin
            own_next[p] = own_exp[p];
            own_tag[p]  = "R5";
            rv[p] = 0;
            rg[p] = 0;
            if (wait_cnt[p] > 0) begin
                wait_cnt[p]--;
                if (wait_cnt[p] == 0 && p == 0) begin
                    own_next[p] = 1;
                    own_tag[p]  = "R2";
                    owns[p]++;
                end
            end
        end
        // bank: releases first, then acquires
        for (int p = 0; p < 2; p++) begin
            if (pend[p] && pend_op[p]) begin
                owner[pend_sem[p]] = -1;
                rv[p] = 1; rg[p] = 1;
                have_run[p] = 1; last_run_op[p] = 1;
                n_done[p]++;
                pend[p] = 0;
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (pend[p] && !pend_op[p]) begin
                rv[p] = 1;
                if (owner[pend_sem[p]] < 0) begin
                    owner[pend_sem[p]] = p;
                    rg[p] = 1;
                    if (n_done[p] >= init_len(p)) begin
                        own_next[p] = 1;
                        owns[p]++;
                        have_run[p] = 1; last_run_op[p] = 0;
                    end
                    n_done[p]++;
                    if (n_done[p] == init_len(p)) wait_cnt[p] = W + 1;
                    retry[p] = 0;
                end else begin
                    denies++;
                    retry[p] = 1;
                end
                pend[p] = 0;
            end
        end
        for (int p = 0; p < 2; p++) begin
            rdy = ((cyc + 2 * p) % 4) != 3;
            stall[p] = 0;
            if (req_valid[p] === 1'b1) begin
                if (rdy) begin
                    eo = exp_op(p, n_done[p]);
                    es = exp_sem(p, n_done[p]);
                    tag = (n_done[p] < init_len(p)) ? "R1" : (retry[p] ? "R9" : "R7");
                    chk(int'(req_op[p]) == eo, tag, "opcode", int'(req_op[p]), eo);
                    chk(int'(req_sem[p]) == es, tag, "semaphore", int'(req_sem[p]), es);
                    if (have_run[p] && n_done[p] >= init_len(p))
                        chk(req_op[p] != last_run_op[p], "R8", "alternation",
                            int'(req_op[p]), int'(!last_run_op[p]));
                    pend[p] = 1; pend_op[p] = eo[0]; pend_sem[p] = es;
                end else begin
                    stall[p] = 1; st_op[p] = req_op[p]; st_sem[p] = int'(req_sem[p]);
                end
            end
            if (own_exp[p]) begin
                hold[p]++;
                ps = hold[p] >= 1 + (owns[p] * 5) % 7;
            end else begin
                ps = (cyc % 3) == 0;
            end
            if (ps && own_exp[p]) begin
                own_next[p] = 0;
                fell_exp[p] = 1;
                own_tag[p]  = "R6";
                hold[p]     = 0;
            end else if (ps) begin
                ign[p] = 1;
            end
            pass_req[p]  = ps;
            req_ready[p] = rdy;
            rsp_valid[p] = rv[p];
            rsp_grant[p] = rg[p];
            own_exp[p]   = own_next[p];
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    initial begin
        for (int s = 0; s < 3; s++) owner[s] = -1;
        for (int p = 0; p < 2; p++) begin
            n_done[p] = 0; wait_cnt[p] = 0; hold[p] = 0; owns[p] = 0;
            own_exp[p] = 0; pend[p] = 0; fell_exp[p] = 0; ign[p] = 0; retry[p] = 0;
            stall[p] = 0; have_run[p] = 0; last_run_op[p] = 0; own_tag[p] = "R5";
            pend_op[p] = 0; pend_sem[p] = 0; st_op[p] = 0; st_sem[p] = 0;
        end
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk(own[p] === 1'b0, "R1", "own in reset", int'(own[p]), 0);
            chk(req_valid[p] === 1'b1 && req_op[p] === 1'b0, "R1", "start acquire",
                int'(req_valid[p]), 1);
            chk(int'(req_sem[p]) == exp_sem(p, 0), "R1", "start index",
                int'(req_sem[p]), exp_sem(p, 0));
        end
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) step(c);
        for (int p = 0; p < 2; p++)
            chk(n_done[p] >= 30, "R12", "rotation progress", n_done[p], 30);
        chk(owns[0] - owns[1] <= 1 && owns[1] - owns[0] <= 1, "R12", "balanced ownership",
            owns[0], owns[1]);
        chk(owns[0] + owns[1] >= 6, "R12", "hand-offs", owns[0] + owns[1], 6);
        chk(denies > 0, "R9", "denies seen", denies, 1);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(NCYC * 10 + 2000);
        if (!finished) begin
            nfail++;
            $display("FAIL R12 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

endmodule